// File: doc/BRIEF.md
# Global Memory Lock Arbiter

This block sits in front of a shared memory used by several hardware threads, each of which keeps its own store buffer. It owns one global lock register that is either free or held by a single thread. A thread running a locked (atomic) instruction raises a take request. The arbiter hands the lock over only when the lock is free and that thread's store buffer has drained. Until then the request simply waits, so a thread that has writes still buffered must drain them first.

While the lock is held, every thread other than the owner is marked blocked. A blocked thread may neither read memory nor move buffered writes into memory. The owner gives the lock back with a release request, which takes effect only once its own buffer is empty. A release raised by any other thread, or raised while the lock is free, changes nothing and produces a one-cycle error pulse. When several threads ask in the same cycle, the winner is picked round-robin, searching upward from the thread that last won. A per-thread fence-ready flag tells each thread when a memory barrier may retire.

Top module: `lock_arbiter`

## Requirements
- R1: During and right after a synchronous reset the lock is free, `owner_id` is 0, and `grant`, `blocked` and `rel_err` are all zero; the first round-robin search begins at thread 0.
- R2: When thread i has `acq_req[i]` and `buf_empty[i]` high in a cycle where the lock is free and i wins arbitration, then after the next clock edge `grant` equals the one-hot value with only bit i set, for exactly one cycle, while `lock_held` is 1 and `owner_id` is i.
- R3: A take request from a thread whose `buf_empty` bit is 0 is never granted; it is granted on the edge after the buffer reports empty, provided the lock is still free.
- R4: While the lock is held, `blocked[i]` is 1 for every thread i other than `owner_id` and 0 for the owner; while the lock is free, all `blocked` bits are 0.
- R5: Take requests raised while the lock is held produce no grant, and the owner does not change.
- R6: A release from the owner while the owner's `buf_empty` bit is 1 leaves the lock free after the next edge.
- R7: A release from the owner while its buffer is not empty is ignored: the lock stays held by the same owner and `rel_err` stays 0.
- R8: A release from a thread that is not the owner, or any release while the lock is free, leaves the lock state unchanged and sets `rel_err` to 1 for exactly one cycle after the next edge.
- R9: Among the threads that are eligible in the same cycle (request high and buffer empty), the winner is the first one found searching upward from the last grantee plus one, wrapping from the highest index back to 0.
- R10: At most one `grant` bit is high in any cycle, and `owner_id` does not change while the lock stays held.
- R11: `fence_ready[i]` follows `buf_empty[i]` in the same cycle and does not depend on the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NUM_THREADS | Per-thread request to take the lock (locked instruction start) |
| rel_req | input | NUM_THREADS | Per-thread request to give the lock back |
| buf_empty | input | NUM_THREADS | Per-thread store buffer is empty |
| grant | output | NUM_THREADS | One-cycle, one-hot pulse naming the thread that just took the lock |
| lock_held | output | 1 | Lock is owned by some thread |
| owner_id | output | ID_W | Index of the owning thread (meaningful while `lock_held` is 1) |
| blocked | output | NUM_THREADS | Thread may not read memory or drain its buffer |
| fence_ready | output | NUM_THREADS | Thread may retire a memory barrier |
| rel_err | output | 1 | One-cycle pulse after an illegal release |

## Verification
The bench builds the block with three threads. This is the smallest count where the round-robin wrap is not a plain toggle and where the thread count is not a power of two, so the modulo index arithmetic really matters. With that size, every last grantee can be combined with every request mask, and every request mask can be swept against every buffer-empty mask. Expected winners are computed in the bench from the search rule. Directed sequences then cover waiting on a busy buffer, owner and non-owner releases, and requests made while the lock is held.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

  // Width of a thread index; at least one bit even for a single thread.
  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lockarb_rr.sv
// Round-robin picker: first requester strictly after `last`, wrapping.
module lockarb_rr #(
  parameter int NUM_THREADS = 4,
  parameter int ID_W        = lockarb_pkg::id_width(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] req,
  input  logic [ID_W-1:0]        last,
  output logic                   valid,
  output logic [ID_W-1:0]        idx,
  output logic [NUM_THREADS-1:0] onehot
);

  always_comb begin
    int cand;
    valid  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int off = 1; off <= NUM_THREADS; off++) begin
      cand = (int'(last) + off) % NUM_THREADS;
      if (!valid && req[cand]) begin
        valid = 1'b1;
        idx   = ID_W'(cand);
      end
    end
    if (valid) onehot[idx] = 1'b1;
  end

  // R9
  always_comb begin
    if (valid) begin
      pick_in_req_chk: assert (req[idx]);
    end
  end

endmodule

// File: rtl/lockarb_state.sv
// Lock register: held flag, owner, last grantee, grant and error pulses.
module lockarb_state #(
  parameter int NUM_THREADS = 4,
  parameter int ID_W        = lockarb_pkg::id_width(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] rel_req,
  input  logic [NUM_THREADS-1:0] buf_empty,
  input  logic                   pick_valid,
  input  logic [ID_W-1:0]        pick_idx,
  input  logic [NUM_THREADS-1:0] pick_onehot,
  output logic                   held,
  output logic [ID_W-1:0]        owner,
  output logic [ID_W-1:0]        last,
  output logic [NUM_THREADS-1:0] grant,
  output logic                   rel_err
);

  localparam logic [ID_W-1:0] LAST_INIT = ID_W'(NUM_THREADS - 1);

  logic [NUM_THREADS-1:0] own_mask;
  logic                   rel_ok;
  logic                   bad_rel;

  always_comb begin
    own_mask = '0;
    if (held) own_mask[owner] = 1'b1;
  end

  assign rel_ok  = held && rel_req[owner] && buf_empty[owner];
  assign bad_rel = |(rel_req & ~own_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      owner   <= '0;
      last    <= LAST_INIT;
      grant   <= '0;
      rel_err <= 1'b0;
    end else begin
      grant   <= '0;
      rel_err <= bad_rel;
      if (held) begin
        if (rel_ok) held <= 1'b0;
      end else if (pick_valid) begin
        held  <= 1'b1;
        owner <= pick_idx;
        last  <= pick_idx;
        grant <= pick_onehot;
      end
    end
  end

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R10
  owner_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (held && $past(held)) |-> $stable(owner));

  // R6
  release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> $past(rel_req[owner] && buf_empty[owner]));

endmodule

// File: rtl/lockarb_view.sv
// Per-thread decode of lock state into blocked and fence-ready flags.
module lockarb_view #(
  parameter int NUM_THREADS = 4,
  parameter int ID_W        = lockarb_pkg::id_width(NUM_THREADS)
) (
  input  logic                   held,
  input  logic [ID_W-1:0]        owner,
  input  logic [NUM_THREADS-1:0] buf_empty,
  output logic [NUM_THREADS-1:0] blocked,
  output logic [NUM_THREADS-1:0] fence_ready
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    assign blocked[t]     = held && (owner != ID_W'(t));
    assign fence_ready[t] = buf_empty[t];
  end

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
  parameter int NUM_THREADS = 4,
  parameter int ID_W        = lockarb_pkg::id_width(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] acq_req,
  input  logic [NUM_THREADS-1:0] rel_req,
  input  logic [NUM_THREADS-1:0] buf_empty,
  output logic [NUM_THREADS-1:0] grant,
  output logic                   lock_held,
  output logic [ID_W-1:0]        owner_id,
  output logic [NUM_THREADS-1:0] blocked,
  output logic [NUM_THREADS-1:0] fence_ready,
  output logic                   rel_err
);

  logic [NUM_THREADS-1:0] eligible;
  logic                   pick_valid;
  logic [ID_W-1:0]        pick_idx;
  logic [NUM_THREADS-1:0] pick_onehot;
  logic [ID_W-1:0]        last_win;

  // A thread may compete only once its store buffer has drained.
  assign eligible = acq_req & buf_empty;

  lockarb_rr #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_rr (
    .req    (eligible),
    .last   (last_win),
    .valid  (pick_valid),
    .idx    (pick_idx),
    .onehot (pick_onehot)
  );

  lockarb_state #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .rel_req     (rel_req),
    .buf_empty   (buf_empty),
    .pick_valid  (pick_valid),
    .pick_idx    (pick_idx),
    .pick_onehot (pick_onehot),
    .held        (lock_held),
    .owner       (owner_id),
    .last        (last_win),
    .grant       (grant),
    .rel_err     (rel_err)
  );

  lockarb_view #(.NUM_THREADS(NUM_THREADS), .ID_W(ID_W)) u_view (
    .held        (lock_held),
    .owner       (owner_id),
    .buf_empty   (buf_empty),
    .blocked     (blocked),
    .fence_ready (fence_ready)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R2 R3
    grant_cond_chk: assert property (@(posedge clk) disable iff (rst)
      grant[t] |-> $past(acq_req[t] && buf_empty[t] && !lock_held));
  end

  // R4
  blocked_count_chk: assert property (@(posedge clk) disable iff (rst)
    lock_held |-> (!blocked[owner_id] && $countones(blocked) == NUM_THREADS - 1));

  // R4
  free_unblocked_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_held |-> (blocked == '0));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rel_err |-> $past(|rel_req));

  // R2
  grant_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> (lock_held && grant[owner_id]));

endmodule

// File: tb/tb_lock_arbiter.sv
`timescale 1ns/1ps
module tb_lock_arbiter;

  localparam int N    = 3;
  localparam int ID_W = lockarb_pkg::id_width(N);
  localparam int ALL  = (1 << N) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    acq_req = '0;
  logic [N-1:0]    rel_req = '0;
  logic [N-1:0]    buf_empty = '1;
  logic [N-1:0]    grant;
  logic            lock_held;
  logic [ID_W-1:0] owner_id;
  logic [N-1:0]    blocked;
  logic [N-1:0]    fence_ready;
  logic            rel_err;

  int n_chk  = 0;
  int n_fail = 0;
  int m_last = N - 1;

  always #2.5 clk = ~clk;

  lock_arbiter #(.NUM_THREADS(N)) dut (
    .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
    .buf_empty(buf_empty), .grant(grant), .lock_held(lock_held),
    .owner_id(owner_id), .blocked(blocked), .fence_ready(fence_ready),
    .rel_err(rel_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int rr_win(input int last, input int mask);
    for (int off = 1; off <= N; off++) begin
      int c;
      c = (last + off) % N;
      if (mask[c]) return c;
    end
    return -1;
  endfunction

  task automatic take(input int t);
    acq_req = N'(1 << t);
    tick();
    chk("R2 grant", int'(grant), 1 << t);
    chk("R2 owner", int'(owner_id), t);
    acq_req = '0;
    m_last = t;
  endtask

  task automatic give(input int t);
    buf_empty = '1;
    rel_req = N'(1 << t);
    tick();
    chk("R6 freed", int'(lock_held), 0);
    chk("R6 no error", int'(rel_err), 0);
    rel_req = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 held in reset", int'(lock_held), 0);
    chk("R1 grant in reset", int'(grant), 0);
    chk("R1 blocked in reset", int'(blocked), 0);
    chk("R1 err in reset", int'(rel_err), 0);
    chk("R1 owner in reset", int'(owner_id), 0);
    rst = 1'b0;
    tick();
    chk("R1 free after reset", int'(lock_held), 0);

    // R1 R9: first search after reset starts at thread 0
    acq_req = N'(ALL);
    tick();
    chk("R1 first winner", int'(grant), 1);
    acq_req = '0;
    m_last = 0;
    tick();
    chk("R2 grant one cycle", int'(grant), 0);
    give(0);

    // R9: every last grantee against every request mask
    for (int l = 0; l < N; l++) begin
      for (int mask = 1; mask <= ALL; mask++) begin
        int w;
        take(l);
        give(l);
        acq_req = N'(mask);
        tick();
        w = rr_win(l, mask);
        chk("R9 winner", int'(grant), 1 << w);
        chk("R9 owner", int'(owner_id), w);
        chk("R4 blocked", int'(blocked), ALL & ~(1 << w));
        acq_req = '0;
        m_last = w;
        give(w);
      end
    end

    // R2 R3 R11: every request mask against every buffer-empty mask
    for (int a = 0; a <= ALL; a++) begin
      for (int e = 0; e <= ALL; e++) begin
        int w;
        acq_req = N'(a);
        buf_empty = N'(e);
        #1;
        chk("R11 fence ready", int'(fence_ready), e);
        tick();
        w = rr_win(m_last, a & e);
        if (w >= 0) begin
          chk("R2 gated grant", int'(grant), 1 << w);
          chk("R2 held", int'(lock_held), 1);
          acq_req = '0;
          m_last = w;
          give(w);
        end else begin
          chk("R3 no grant on busy buffer", int'(grant), 0);
          chk("R3 stays free", int'(lock_held), 0);
          acq_req = '0;
        end
        buf_empty = '1;
      end
    end

    // R3: thread 2 waits while its buffer drains
    acq_req = 3'b100;
    buf_empty = 3'b011;
    repeat (3) begin
      tick();
      chk("R3 waiting", int'(lock_held), 0);
    end
    buf_empty = '1;
    tick();
    chk("R3 granted after drain", int'(grant), 3'b100);
    acq_req = '0;
    m_last = 2;

    // R5: requests while held
    acq_req = 3'b011;
    repeat (2) begin
      tick();
      chk("R5 no grant while held", int'(grant), 0);
      chk("R5 owner kept", int'(owner_id), 2);
      chk("R4 others blocked", int'(blocked), 3'b011);
    end
    acq_req = '0;

    // R7: owner release with buffer not empty
    buf_empty = 3'b011;
    rel_req = 3'b100;
    tick();
    chk("R7 still held", int'(lock_held), 1);
    chk("R7 no error", int'(rel_err), 0);
    rel_req = '0;
    buf_empty = '1;

    // R8: release from a non-owner
    rel_req = 3'b001;
    tick();
    chk("R8 error pulse", int'(rel_err), 1);
    chk("R8 still held", int'(lock_held), 1);
    chk("R8 owner kept", int'(owner_id), 2);
    rel_req = '0;
    tick();
    chk("R8 pulse ends", int'(rel_err), 0);

    give(2);
    chk("R4 free unblocked", int'(blocked), 0);

    // R8: release while free
    rel_req = 3'b010;
    tick();
    chk("R8 error when free", int'(rel_err), 1);
    chk("R8 stays free", int'(lock_held), 0);
    rel_req = '0;
    tick();
    chk("R8 pulse ends when free", int'(rel_err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule